// File: doc/BRIEF.md
# Hardware Cursor Overlay

This block lays a 64x64 pointer image over the pixel stream leaving the display pipeline, one pixel per clock. Every clock it receives the raster column and row of the pixel entering it, the screen colour of that pixel, and the cursor settings: enable, position, two solid colours, a base address for the image in a local map RAM, and a flag for 16-bit-per-pixel operation. Two clocks later it emits either the screen colour, its bitwise inverse, or one of the two solid colours.

The image stores two bits per pixel, one in each of two planes (A and B). A pixel with A=0 shows a solid colour that B chooses. A pixel with A=1 and B=0 lets the screen through. A pixel with A=1 and B=1 inverts the screen. The block reads the image from the map RAM through a synchronous read port with one clock of latency. It fetches the words of each 16-pixel group a few clocks before the raster reaches that group. In 16-bit colour mode one map word packs both planes for a group, and each map bit is shown on two neighbouring pixels. In that mode the programmed X position counts in half-pixels.

Top module: `cursor_overlay`

## Requirements
- R1: While reset is asserted and on the first clock after its release, `pix_out` is zero. `map_rd_en` stays low whenever the raster row is outside the cursor rows.
- R2: `pix_out` carries the result for the pixel presented two clocks earlier. A pixel outside the cursor rows comes out unchanged.
- R3: A pixel is covered only when 0 <= `raster_x` - start < 64 and 0 <= `raster_y` - `cur_y` < 64. The start is `cur_x` in normal mode and `cur_x` >> 1 in 16-bit mode. Pixels in a cursor row but outside the columns come out unchanged.
- R4: A covered pixel with A=0 shows `cur_bg` when B=0 and `cur_fg` when B=1.
- R5: A covered pixel with A=1 and B=0 shows the screen pixel unchanged.
- R6: A covered pixel with A=1 and B=1 shows the bitwise inverse of the screen pixel.
- R7: With `cur_en` low at the input clock, the pixel comes out unchanged.
- R8: In normal mode, row r and group g (columns 16g..16g+15) use word offset r*8 + 2g for plane A and r*8 + 2g + 1 for plane B. Column 16g+j uses bit 15-j of each word. The A read is issued when `raster_x` - start = 16g-4 and the B read at 16g-3.
- R9: The map base counts in 1024-byte units, so each read address equals {`map_base`, 9-bit offset in 16-bit words}.
- R10: In 16-bit mode, group g of row r uses the single word at offset r*8 + g. Bits [15:8] hold plane A and bits [7:0] hold plane B. Map bit k (k = 0..7) sits at bit 7-k of each byte and covers columns 16g+2k and 16g+2k+1. It is read when `raster_x` - start = 16g-4, with no second read for the group.
- R11: A raster line that crosses the whole cursor span issues exactly 8 reads in normal mode and 4 in 16-bit mode when its row is a cursor row, and none otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| raster_x | input | COORD_W | Column of the incoming pixel |
| raster_y | input | COORD_W | Row of the incoming pixel |
| pix_in | input | PIX_W | Incoming screen pixel |
| cur_en | input | 1 | Cursor overlay enable |
| wide_mode | input | 1 | 16-bit colour layout (packed planes, doubled bits, half-pixel X) |
| cur_x | input | COORD_W | Cursor left edge (half-pixels in 16-bit mode) |
| cur_y | input | COORD_W | Cursor top row |
| cur_fg | input | PIX_W | Solid colour for A=0, B=1 |
| cur_bg | input | PIX_W | Solid colour for A=0, B=0 |
| map_base | input | MAP_AW-9 | Image base in 1024-byte units |
| map_rd_en | output | 1 | Map RAM read strobe |
| map_addr | output | MAP_AW | Map RAM word address |
| map_rdata | input | 16 | Map RAM data, valid the clock after the read |
| pix_out | output | PIX_W | Overlaid pixel, two clocks after input |

## Verification
The checks on the read port assume that the raster column advances by exactly one per clock through each cursor row. They also assume the line begins at least four columns before the cursor start, so the prefetch points come before the pixels that need them. The stimulus drives each line as an unbroken run that starts eight columns left of the start and runs past the right edge. Between scenarios it places flush pixels far outside the cursor rows, so the solid colours and mode can change without affecting a covered pixel still in the pipeline. The read-pair check also needs `wide_mode` to be held steady across a line, and the stimulus changes it only between scenarios.

// File: rtl/cursor_ovl_pkg.sv
package cursor_ovl_pkg;

    localparam int MAP_DW     = 16;   // map RAM word width
    localparam int WIN        = 64;   // cursor side in pixels
    localparam int GRP        = 16;   // screen pixels served by one word group
    localparam int LEAD       = 4;    // columns of prefetch lead ahead of a group
    localparam int ROW_WORDS  = 8;    // map words per cursor row
    localparam int OFS_W      = 9;    // word offset bits inside a 1 KiB image

    typedef enum logic [1:0] {
        RD_NONE,
        RD_PLANE_A,
        RD_PLANE_B,
        RD_PACKED
    } rd_kind_e;

    // spread a byte of map bits so each one covers two adjacent pixels
    function automatic logic [MAP_DW-1:0] widen_byte(input logic [7:0] b);
        logic [MAP_DW-1:0] r;
        for (int i = 0; i < 8; i++) begin
            r[2*i]   = b[i];
            r[2*i+1] = b[i];
        end
        return r;
    endfunction

endpackage

// File: rtl/cursor_window.sv
module cursor_window #(
    parameter int COORD_W = 12
) (
    input  logic [COORD_W-1:0] rx,
    input  logic [COORD_W-1:0] ry,
    input  logic [COORD_W-1:0] cx,
    input  logic [COORD_W-1:0] cy,
    input  logic               wide,
    output logic               hit,
    output logic               row_ok,
    output logic [5:0]         col,
    output logic [5:0]         row,
    output logic               fetch_ok,
    output logic [1:0]         fetch_grp,
    output logic [3:0]         fetch_phase
);
    import cursor_ovl_pkg::*;

    localparam int DW = COORD_W + 1;

    logic [COORD_W-1:0] start_x;
    logic [DW-1:0]      dx, dy, lead;

    always_comb begin
        start_x     = wide ? (cx >> 1) : cx;
        dx          = {1'b0, rx} - {1'b0, start_x};
        dy          = {1'b0, ry} - {1'b0, cy};
        lead        = dx + DW'(LEAD);
        row_ok      = dy < DW'(WIN);
        hit         = row_ok && (dx < DW'(WIN));
        col         = dx[5:0];
        row         = dy[5:0];
        fetch_ok    = row_ok && (lead < DW'(WIN));
        fetch_grp   = lead[5:4];
        fetch_phase = lead[3:0];
    end

endmodule

// File: rtl/cursor_pixel_mux.sv
module cursor_pixel_mux #(
    parameter int PIX_W = 16
) (
    input  logic             hit,
    input  logic             a_bit,
    input  logic             b_bit,
    input  logic [PIX_W-1:0] scr,
    input  logic [PIX_W-1:0] fg,
    input  logic [PIX_W-1:0] bg,
    output logic [PIX_W-1:0] pix
);
    always_comb begin
        if (!hit)        pix = scr;
        else if (!a_bit) pix = b_bit ? fg : bg;
        else if (b_bit)  pix = ~scr;
        else             pix = scr;
    end
endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay #(
    parameter int PIX_W   = 16,
    parameter int COORD_W = 12,
    parameter int MAP_AW  = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [COORD_W-1:0]      raster_x,
    input  logic [COORD_W-1:0]      raster_y,
    input  logic [PIX_W-1:0]        pix_in,
    input  logic                    cur_en,
    input  logic                    wide_mode,
    input  logic [COORD_W-1:0]      cur_x,
    input  logic [COORD_W-1:0]      cur_y,
    input  logic [PIX_W-1:0]        cur_fg,
    input  logic [PIX_W-1:0]        cur_bg,
    input  logic [MAP_AW-10:0]      map_base,
    output logic                    map_rd_en,
    output logic [MAP_AW-1:0]       map_addr,
    input  logic [15:0]             map_rdata,
    output logic [PIX_W-1:0]        pix_out
);
    import cursor_ovl_pkg::*;

    localparam int BASE_W = MAP_AW - OFS_W;

    typedef struct packed {
        logic [MAP_DW-1:0] a_nxt;
        logic [MAP_DW-1:0] b_nxt;
        logic [MAP_DW-1:0] a_cur;
        logic [MAP_DW-1:0] b_cur;
        rd_kind_e          rd_kind;
        logic              s1_hit;
        logic [3:0]        s1_pos;
        logic [PIX_W-1:0]  s1_scr;
        logic [PIX_W-1:0]  out;
    } ovl_state_t;

    ovl_state_t st_q, st_d;

    logic       hit, row_ok, fetch_ok;
    logic [5:0] col, row;
    logic [1:0] fetch_grp;
    logic [3:0] fetch_phase;
    logic [2:0] word_sel;
    logic [PIX_W-1:0] mux_pix;

    cursor_window #(.COORD_W(COORD_W)) u_win (
        .rx         (raster_x),
        .ry         (raster_y),
        .cx         (cur_x),
        .cy         (cur_y),
        .wide       (wide_mode),
        .hit        (hit),
        .row_ok     (row_ok),
        .col        (col),
        .row        (row),
        .fetch_ok   (fetch_ok),
        .fetch_grp  (fetch_grp),
        .fetch_phase(fetch_phase)
    );

    cursor_pixel_mux #(.PIX_W(PIX_W)) u_mux (
        .hit  (st_q.s1_hit),
        .a_bit(st_q.a_cur[~st_q.s1_pos]),
        .b_bit(st_q.b_cur[~st_q.s1_pos]),
        .scr  (st_q.s1_scr),
        .fg   (cur_fg),
        .bg   (cur_bg),
        .pix  (mux_pix)
    );

    always_comb begin
        st_d         = st_q;
        st_d.rd_kind = RD_NONE;
        map_rd_en    = 1'b0;
        word_sel     = '0;

        // issue reads ahead of the group that needs them
        if (fetch_ok && fetch_phase == 4'd0) begin
            map_rd_en    = 1'b1;
            word_sel     = wide_mode ? {1'b0, fetch_grp} : {fetch_grp, 1'b0};
            st_d.rd_kind = wide_mode ? RD_PACKED : RD_PLANE_A;
        end else if (fetch_ok && fetch_phase == 4'd1 && !wide_mode) begin
            map_rd_en    = 1'b1;
            word_sel     = {fetch_grp, 1'b1};
            st_d.rd_kind = RD_PLANE_B;
        end
        map_addr = {map_base[BASE_W-1:0], row, word_sel};

        // capture returning map data into the staging words
        unique case (st_q.rd_kind)
            RD_PLANE_A: st_d.a_nxt = map_rdata;
            RD_PLANE_B: st_d.b_nxt = map_rdata;
            RD_PACKED: begin
                st_d.a_nxt = widen_byte(map_rdata[15:8]);
                st_d.b_nxt = widen_byte(map_rdata[7:0]);
            end
            default: ;
        endcase

        // switch to the staged group on its first column
        if (hit && col[3:0] == 4'd0) begin
            st_d.a_cur = st_q.a_nxt;
            st_d.b_cur = st_q.b_nxt;
        end

        // stage 1 and output register
        st_d.s1_hit = cur_en && hit;
        st_d.s1_pos = col[3:0];
        st_d.s1_scr = pix_in;
        st_d.out    = mux_pix;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.rd_kind <= RD_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign pix_out = st_q.out;

endmodule

// File: rtl/cursor_ovl_chk.sv
module cursor_ovl_chk #(
    parameter int PIX_W   = 16,
    parameter int COORD_W = 12,
    parameter int MAP_AW  = 12
) (
    input logic                clk,
    input logic                rst_n,
    input logic [COORD_W-1:0]  raster_y,
    input logic [COORD_W-1:0]  cur_y,
    input logic [PIX_W-1:0]    pix_in,
    input logic                cur_en,
    input logic                wide_mode,
    input logic [MAP_AW-10:0]  map_base,
    input logic                map_rd_en,
    input logic [MAP_AW-1:0]   map_addr,
    input logic [PIX_W-1:0]    pix_out
);
    localparam int DW     = COORD_W + 1;
    localparam int BASE_W = MAP_AW - 9;

    logic [1:0]    since_rst;
    logic [DW-1:0] row_dist;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    assign row_dist = {1'b0, raster_y} - {1'b0, cur_y};

    assert_reset_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd0) |-> (pix_out == '0));

    assert_disabled_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2 && !$past(cur_en, 2)) |-> (pix_out == $past(pix_in, 2)));

    assert_base_field_R9: assert property (@(posedge clk) disable iff (!rst_n)
        map_rd_en |-> (map_addr[MAP_AW-1 -: BASE_W] == map_base));

    assert_row_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
        map_rd_en |-> (row_dist < DW'(64)));

    assert_packed_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wide_mode && map_rd_en) |=> (!map_rd_en || !wide_mode));

endmodule

bind cursor_overlay cursor_ovl_chk #(
    .PIX_W  (PIX_W),
    .COORD_W(COORD_W),
    .MAP_AW (MAP_AW)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .raster_y (raster_y),
    .cur_y    (cur_y),
    .pix_in   (pix_in),
    .cur_en   (cur_en),
    .wide_mode(wide_mode),
    .map_base (map_base),
    .map_rd_en(map_rd_en),
    .map_addr (map_addr),
    .pix_out  (pix_out)
);

// File: tb/tb_cursor_overlay.sv
`timescale 1ns/1ps
module tb_cursor_overlay;
    localparam int PIX_W   = 16;
    localparam int COORD_W = 12;
    localparam int MAP_AW  = 12;
    localparam int DEPTH   = 1 << MAP_AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [COORD_W-1:0] raster_x = '0, raster_y = '0, cur_x = '0, cur_y = '0;
    logic [PIX_W-1:0]   pix_in = '0, cur_fg = '0, cur_bg = '0;
    logic               cur_en = 1'b0, wide_mode = 1'b0;
    logic [MAP_AW-10:0] map_base = '0;
    logic               map_rd_en;
    logic [MAP_AW-1:0]  map_addr;
    logic [15:0]        map_rdata = '0;
    logic [PIX_W-1:0]   pix_out;

    logic [15:0] mem [0:DEPTH-1];

    int vectors = 0, fails = 0, line_reads = 0;
    logic [PIX_W-1:0] e1, e2;
    string t1, t2;
    bit v1 = 0, v2 = 0;

    always #2 clk = ~clk;   // 250 MHz

    cursor_overlay #(.PIX_W(PIX_W), .COORD_W(COORD_W), .MAP_AW(MAP_AW)) dut (
        .clk(clk), .rst_n(rst_n), .raster_x(raster_x), .raster_y(raster_y),
        .pix_in(pix_in), .cur_en(cur_en), .wide_mode(wide_mode),
        .cur_x(cur_x), .cur_y(cur_y), .cur_fg(cur_fg), .cur_bg(cur_bg),
        .map_base(map_base), .map_rd_en(map_rd_en), .map_addr(map_addr),
        .map_rdata(map_rdata), .pix_out(pix_out)
    );

    always_ff @(posedge clk) if (map_rd_en) map_rdata <= mem[map_addr];

    task automatic check(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [PIX_W-1:0] pattern(input int x, input int y);
        return PIX_W'((x * 37) ^ (y * 1123) ^ 16'h5a3c);
    endfunction

    function automatic int start_col();
        return wide_mode ? int'(cur_x) / 2 : int'(cur_x);
    endfunction

    // expected output for one pixel, from the requirements
    function automatic void model(input int x, input int y,
                                  output logic [PIX_W-1:0] e, output string tag);
        int dx, dy, g, j, ofs;
        logic a, b;
        logic [15:0] w;
        logic [PIX_W-1:0] p;
        p  = pattern(x, y);
        dx = x - start_col();
        dy = y - int'(cur_y);
        if (dy < 0 || dy >= 64) begin e = p; tag = "R2"; return; end
        if (dx < 0 || dx >= 64) begin e = p; tag = "R3"; return; end
        if (!cur_en) begin e = p; tag = "R7"; return; end
        g   = dx / 16;
        j   = dx % 16;
        ofs = int'(map_base) * 512 + dy * 8;
        if (wide_mode) begin
            w = mem[ofs + g];
            a = w[15 - j / 2];
            b = w[7 - j / 2];
        end else begin
            a = mem[ofs + 2 * g][15 - j];
            b = mem[ofs + 2 * g + 1][15 - j];
        end
        if (!a)      begin e = b ? cur_fg : cur_bg; tag = "R4"; end
        else if (!b) begin e = p;  tag = "R5"; end
        else         begin e = ~p; tag = "R6"; end
        if (wide_mode) tag = {tag, "/R10"};
    endfunction

    task automatic drive(input int x, input int y);
        logic [PIX_W-1:0] e;
        string tag;
        int lead, exp_addr;
        bit exp_rd;
        @(negedge clk);
        if (v2) check(t2, int'(pix_out), int'(e2));
        raster_x = COORD_W'(x);
        raster_y = COORD_W'(y);
        pix_in   = pattern(x, y);
        model(x, y, e, tag);
        e2 = e1; t2 = t1; v2 = v1;
        e1 = e;  t1 = tag; v1 = 1'b1;
        // expected read strobe for this column (R8, R9, R10)
        lead = x - start_col() + 4;
        exp_rd = 1'b0;
        exp_addr = int'(map_base) * 512 + (y - int'(cur_y)) * 8;
        if (y - int'(cur_y) >= 0 && y - int'(cur_y) < 64 && lead >= 0 && lead < 64) begin
            if (lead % 16 == 0) begin
                exp_rd = 1'b1;
                exp_addr += wide_mode ? lead / 16 : 2 * (lead / 16);
            end else if (lead % 16 == 1 && !wide_mode) begin
                exp_rd = 1'b1;
                exp_addr += 2 * (lead / 16) + 1;
            end
        end
        #1;
        if (map_rd_en) line_reads++;
        if (exp_rd || map_rd_en) begin
            check(wide_mode ? "R10 read" : "R8 read", int'(map_rd_en), int'(exp_rd));
            if (map_rd_en && exp_rd) begin
                check("R9 base", int'(map_addr) / 512, int'(map_base));
                check(wide_mode ? "R10 addr" : "R8 addr", int'(map_addr), exp_addr);
            end
        end
    endtask

    task automatic flush();
        drive(4000, 4000);
        drive(4000, 4000);
    endtask

    task automatic run_lines(input int y0, input int y1);
        int sx;
        sx = start_col();
        for (int y = y0; y <= y1; y++) begin
            int dy, want;
            line_reads = 0;
            for (int x = sx - 8; x <= sx + 71; x++) drive(x, y);
            dy = y - int'(cur_y);
            want = (dy >= 0 && dy < 64) ? (wide_mode ? 4 : 8) : 0;
            check("R11 reads per line", line_reads, want);
        end
        flush();
    endtask

    task automatic setup(input int cx, input int cy, input bit en, input bit wide,
                         input int base, input int fg, input int bg);
        cur_x = COORD_W'(cx); cur_y = COORD_W'(cy);
        cur_en = en; wide_mode = wide;
        map_base = (MAP_AW-9)'(base);
        cur_fg = PIX_W'(fg); cur_bg = PIX_W'(bg);
    endtask

    task automatic t_reset();
        setup(100, 3000, 1'b1, 1'b0, 0, 16'h1234, 16'h4321);
        raster_x = 12'd10; raster_y = 12'd10; pix_in = 16'hffff;
        #1;
        check("R1 out in reset", int'(pix_out), 0);
        check("R1 strobe in reset", int'(map_rd_en), 0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1 out after release", int'(pix_out), 0);
        flush();
    endtask

    task automatic t_normal();   // R3 R4 R5 R6 R8 R11
        setup(100, 50, 1'b1, 1'b0, 2, 16'hf00d, 16'h0bad);
        run_lines(46, 117);
    endtask

    task automatic t_disabled(); // R7
        setup(100, 50, 1'b0, 1'b0, 2, 16'hf00d, 16'h0bad);
        run_lines(48, 60);
    endtask

    task automatic t_wide();     // R10
        setup(301, 10, 1'b1, 1'b1, 5, 16'hc0de, 16'h7777);
        run_lines(8, 76);
    endtask

    task automatic t_corner();   // R3 at the top-left, base 0
        setup(4, 0, 1'b1, 1'b0, 0, 16'h8001, 16'h00ff);
        run_lines(0, 65);
    endtask

    task automatic t_top_base(); // R9 with the largest base
        setup(700, 400, 1'b1, 1'b0, 7, 16'haaaa, 16'h5555);
        run_lines(398, 470);
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) mem[i] = 16'((i * 40503 + 12345) ^ (i << 7));
        t_reset();
        t_normal();
        t_disabled();
        t_wide();
        t_corner();
        t_top_base();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule